// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is a single general register of a timer channel. A 4-bit I/O control code turns it into either an output-compare register or an input-capture register. In compare mode it drives an output pin. Writing the code sets the pin's starting level. Each compare-match strobe after that leaves the pin alone, forces it low, forces it high, or inverts it.

In capture mode the register copies the free-running counter value and raises a sticky flag. The trigger is a chosen edge of an external capture pin, after a two-flop synchroniser. It can instead be every count event reported by the neighbouring channel's counter. The neighbour source gives no captures while that neighbour counts at the undivided system clock.

A buffer-mode input turns off all compare and capture activity. The register can still be loaded through a plain write port. The counter, the prescaler and the bus fabric sit outside the block.

Top module: `timer_capcomp_ch`

## Requirements
- R1: After reset the I/O control code is 0000, and `outPin`, `outEn`, `gr` and `capFlag` are all zero.
- R2: When `cfgWe` writes a code with bit 3 = 0, `outPin` takes code bit 2 at that clock edge. In compare mode `outEn` is 1 exactly when code bits 1:0 are not 00.
- R3: In compare mode a `cmpMatch` strobe acts on `outPin` at the next clock edge, as selected by code bits 1:0:
  - 00 leaves the pin unchanged.
  - 01 drives it to 0.
  - 10 drives it to 1.
  - 11 inverts it.
  - A configuration write in the same cycle takes priority.
- R4: Code 1000 captures on a rising edge of `capPin`. If the new level is first sampled at edge k, then `gr` loads the counter value presented at edge k+2.
- R5: Code 1001 captures on a falling edge of `capPin`, with the same latency as R4.
- R6: Codes 1010 and 1011 capture on both edges of `capPin`, with the same latency as R4.
- R7: Codes 11xx ignore `capPin`. They capture the counter value at every clock edge where `adjCountEvt` is 1, but never while `adjFastClk` is 1.
- R8: While `bufferMode` is 1, no capture happens and `cmpMatch` does not change `outPin`.
- R9: Every capture sets `capFlag`. A 1 on `flagClr` clears it. A capture in the same cycle as a clear wins.
- R10: `regWe` loads `regData` into `gr`. A capture in the same cycle takes priority over the write.
- R11: In capture mode (code bit 3 = 1) `outEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the I/O control code |
| cfgData | input | 4 | New I/O control code |
| regWe | input | 1 | Write strobe for the general register |
| regData | input | CNT_W | Data for the general register |
| flagClr | input | 1 | Clears the capture flag when 1 |
| bufferMode | input | 1 | Suppresses compare and capture activity |
| adjFastClk | input | 1 | Neighbour counts at the undivided clock |
| counter | input | CNT_W | Free-running counter value |
| cmpMatch | input | 1 | Compare-match strobe |
| capPin | input | 1 | Asynchronous capture pin |
| adjCountEvt | input | 1 | Neighbour counter count-up/count-down event |
| outPin | output | 1 | Compare output level |
| outEn | output | 1 | Compare output enable |
| gr | output | CNT_W | General register contents |
| capFlag | output | 1 | Sticky capture flag |

## Verification
The hardest case to reach from the ports is the exact capture cycle for pin edges. The pin passes through a synchroniser and an edge history flop before it can trigger a capture, so the counter value stored is two clocks later than the edge where the pin changes. The bench runs its own free-running counter. It changes the pin on a falling clock edge and records its counter value just before the third rising edge. Each capture test first preloads `gr` with a marker and clears the flag, so a missed capture, an extra capture or a wrong-edge capture all show up at the ports. Every compare and capture code is swept in turn.

// File: rtl/tci_pkg.sv
`timescale 1ns/1ps
package tci_pkg;
  localparam int IO_W = 4;

  typedef struct packed {
    logic capture;
    logic pinLoad;
    logic pinLoadVal;
    logic pinSet;
    logic pinClr;
    logic pinToggle;
  } chanStrobes_t;
endpackage

// File: rtl/tci_sync.sv
`timescale 1ns/1ps
module tci_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tci_ctrl.sv
`timescale 1ns/1ps
module tci_ctrl
  import tci_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IO_W-1:0]  cfgData,
  input  logic             bufferMode,
  input  logic             adjFastClk,
  input  logic             cmpMatch,
  input  logic             capPin,
  input  logic             adjCountEvt,
  output logic [IO_W-1:0]  ioCtlQ,
  output logic             outEnable,
  output chanStrobes_t     strb
);
  logic pinSync;
  logic pinPrev;
  logic riseEdge;
  logic fallEdge;
  logic cmpMode;
  logic adjSrc;
  logic pinCapHit;
  logic matchLive;

  always_ff @(posedge clk) begin
    if (!rstN)      ioCtlQ <= '0;
    else if (cfgWe) ioCtlQ <= cfgData;
  end

  tci_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (capPin),
    .dout (pinSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinSync;
  end

  assign riseEdge = pinSync & ~pinPrev;
  assign fallEdge = ~pinSync & pinPrev;
  assign cmpMode  = ~ioCtlQ[3];
  assign adjSrc   = ioCtlQ[3] & ioCtlQ[2];

  always_comb begin
    unique case (ioCtlQ[1:0])
      2'b00:   pinCapHit = riseEdge;
      2'b01:   pinCapHit = fallEdge;
      default: pinCapHit = riseEdge | fallEdge;
    endcase
  end

  assign matchLive = cmpMode & cmpMatch & ~bufferMode;

  always_comb begin
    strb            = '0;
    strb.capture    = ioCtlQ[3] & ~bufferMode &
                      (adjSrc ? (adjCountEvt & ~adjFastClk) : pinCapHit);
    strb.pinLoad    = cfgWe & ~cfgData[3];
    strb.pinLoadVal = cfgData[2];
    strb.pinClr     = matchLive & (ioCtlQ[1:0] == 2'b01);
    strb.pinSet     = matchLive & (ioCtlQ[1:0] == 2'b10);
    strb.pinToggle  = matchLive & (ioCtlQ[1:0] == 2'b11);
  end

  assign outEnable = cmpMode & (|ioCtlQ[1:0]);
endmodule

// File: rtl/tci_data.sv
`timescale 1ns/1ps
module tci_data
  import tci_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobes_t     strb,
  input  logic             regWe,
  input  logic [CNT_W-1:0] regData,
  input  logic             flagClr,
  input  logic [CNT_W-1:0] counter,
  output logic [CNT_W-1:0] grQ,
  output logic             flagQ,
  output logic             pinQ
);
  always_ff @(posedge clk) begin
    if (!rstN)             grQ <= '0;
    else if (strb.capture) grQ <= counter;
    else if (regWe)        grQ <= regData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.capture) flagQ <= 1'b1;
    else if (flagClr)      flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pinQ <= 1'b0;
    else if (strb.pinLoad)   pinQ <= strb.pinLoadVal;
    else if (strb.pinSet)    pinQ <= 1'b1;
    else if (strb.pinClr)    pinQ <= 1'b0;
    else if (strb.pinToggle) pinQ <= ~pinQ;
  end
endmodule

// File: rtl/timer_capcomp_ch.sv
`timescale 1ns/1ps
module timer_capcomp_ch
  import tci_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [3:0]       cfgData,
  input  logic             regWe,
  input  logic [CNT_W-1:0] regData,
  input  logic             flagClr,
  input  logic             bufferMode,
  input  logic             adjFastClk,
  input  logic [CNT_W-1:0] counter,
  input  logic             cmpMatch,
  input  logic             capPin,
  input  logic             adjCountEvt,
  output logic             outPin,
  output logic             outEn,
  output logic [CNT_W-1:0] gr,
  output logic             capFlag
);
  chanStrobes_t    strb;
  logic [IO_W-1:0] ioCtlQ;

  tci_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgData     (cfgData),
    .bufferMode  (bufferMode),
    .adjFastClk  (adjFastClk),
    .cmpMatch    (cmpMatch),
    .capPin      (capPin),
    .adjCountEvt (adjCountEvt),
    .ioCtlQ      (ioCtlQ),
    .outEnable   (outEn),
    .strb        (strb)
  );

  tci_data #(.CNT_W(CNT_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regWe   (regWe),
    .regData (regData),
    .flagClr (flagClr),
    .counter (counter),
    .grQ     (gr),
    .flagQ   (capFlag),
    .pinQ    (outPin)
  );
endmodule

// File: rtl/tci_chk.sv
`timescale 1ns/1ps
module tci_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [3:0]       cfgData,
  input logic [3:0]       ioCtlQ,
  input logic             regWe,
  input logic [CNT_W-1:0] regData,
  input logic             flagClr,
  input logic             bufferMode,
  input logic             adjFastClk,
  input logic [CNT_W-1:0] counter,
  input logic             cmpMatch,
  input logic             adjCountEvt,
  input logic             outPin,
  input logic             outEn,
  input logic [CNT_W-1:0] gr,
  input logic             capFlag
);
  assert_cfg_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgData[3]) |=> (outPin == $past(cfgData[2])));

  assert_match_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ioCtlQ[3] && ioCtlQ[1:0] == 2'b10 && cmpMatch && !bufferMode && !cfgWe) |=> outPin);

  assert_match_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ioCtlQ[3] && ioCtlQ[1:0] == 2'b11 && cmpMatch && !bufferMode && !cfgWe)
      |=> (outPin != $past(outPin)));

  assert_adj_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ioCtlQ[3:2] == 2'b11 && adjCountEvt && !adjFastClk && !bufferMode)
      |=> (gr == $past(counter) && capFlag));

  assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bufferMode && !regWe) |=> $stable(gr));

  assert_buffer_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bufferMode && !cfgWe) |=> $stable(outPin));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);

  assert_reg_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !ioCtlQ[3]) |=> (gr == $past(regData)));

  assert_cap_no_drive_R11: assert property (@(posedge clk) disable iff (!rstN)
    ioCtlQ[3] |-> !outEn);
endmodule

bind timer_capcomp_ch tci_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWe       (cfgWe),
  .cfgData     (cfgData),
  .ioCtlQ      (ioCtlQ),
  .regWe       (regWe),
  .regData     (regData),
  .flagClr     (flagClr),
  .bufferMode  (bufferMode),
  .adjFastClk  (adjFastClk),
  .counter     (counter),
  .cmpMatch    (cmpMatch),
  .adjCountEvt (adjCountEvt),
  .outPin      (outPin),
  .outEn       (outEn),
  .gr          (gr),
  .capFlag     (capFlag)
);

// File: tb/timer_capcomp_ch_tb.sv
`timescale 1ns/1ps
module timer_capcomp_ch_tb;
  localparam int W = 16;
  localparam logic [W-1:0] MARK = 16'hDEAD;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWe = 1'b0;
  logic [3:0]   cfgData = '0;
  logic         regWe = 1'b0;
  logic [W-1:0] regData = '0;
  logic         flagClr = 1'b0;
  logic         bufferMode = 1'b0;
  logic         adjFastClk = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         cmpMatch = 1'b0;
  logic         capPin = 1'b0;
  logic         adjCountEvt = 1'b0;
  logic         outPin;
  logic         outEn;
  logic [W-1:0] gr;
  logic         capFlag;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) cnt <= cnt + 16'd3;

  timer_capcomp_ch #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .regWe(regWe), .regData(regData), .flagClr(flagClr),
    .bufferMode(bufferMode), .adjFastClk(adjFastClk), .counter(cnt),
    .cmpMatch(cmpMatch), .capPin(capPin), .adjCountEvt(adjCountEvt),
    .outPin(outPin), .outEn(outEn), .gr(gr), .capFlag(capFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] code);
    cfgWe = 1'b1; cfgData = code;
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseMatch();
    cmpMatch = 1'b1;
    @(posedge clk); @(negedge clk);
    cmpMatch = 1'b0;
  endtask

  task automatic prep();
    regWe = 1'b1; regData = MARK; flagClr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0; flagClr = 1'b0;
  endtask

  task automatic capEdge(input logic lvl, input logic want, input string req);
    logic [W-1:0] e;
    prep();
    capPin = lvl;
    @(posedge clk); @(posedge clk); @(negedge clk);
    e = cnt;
    @(posedge clk); @(negedge clk);
    chk({req, " gr"}, gr, want ? e : MARK);
    chk({req, " flag"}, capFlag, want);
    repeat (3) @(negedge clk);
    chk({req, " gr settled"}, gr, want ? e : MARK);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] e;
    logic         ep;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outPin", outPin, 0);
    chk("R1 outEn", outEn, 0);
    chk("R1 gr", gr, 0);
    chk("R1 capFlag", capFlag, 0);

    // R2 / R3 sweep over every compare code
    for (int c = 0; c < 8; c++) begin
      logic [3:0] code;
      code = 4'(c);
      cfgWrite(code);
      chk("R2 initial level", outPin, code[2]);
      chk("R2 enable", outEn, code[1:0] != 2'b00);
      case (code[1:0])
        2'b00: ep = code[2];
        2'b01: ep = 1'b0;
        2'b10: ep = 1'b1;
        default: ep = ~code[2];
      endcase
      pulseMatch();
      chk("R3 first match", outPin, ep);
      if (code[1:0] == 2'b11) ep = code[2];
      pulseMatch();
      chk("R3 second match", outPin, ep);
    end

    // R3 configuration write beats a same-cycle match
    cfgWrite(4'b0010);
    cfgWe = 1'b1; cfgData = 4'b0010; cmpMatch = 1'b1;
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0; cmpMatch = 1'b0;
    chk("R3 cfg priority", outPin, 0);

    // R4 R5 R6 R7 R11 sweep over every capture code
    repeat (4) @(negedge clk);
    for (int c = 8; c < 16; c++) begin
      logic [3:0] code;
      code = 4'(c);
      cfgWrite(code);
      chk("R11 enable low", outEn, 0);
      capEdge(1'b1, (code == 4'b1000) || (code[3:1] == 3'b101),
              code[2] ? "R7 pin ignored rise" : "R4/R6 rise");
      capEdge(1'b0, (code == 4'b1001) || (code[3:1] == 3'b101),
              code[2] ? "R7 pin ignored fall" : "R5/R6 fall");
    end

    // R7 neighbour events
    for (int c = 12; c < 16; c++) begin
      cfgWrite(4'(c));
      prep();
      adjCountEvt = 1'b1; e = cnt;
      @(posedge clk); @(negedge clk);
      adjCountEvt = 1'b0;
      chk("R7 event capture", gr, e);
      chk("R7 event flag", capFlag, 1);
      prep();
      adjFastClk = 1'b1; adjCountEvt = 1'b1;
      @(posedge clk); @(negedge clk);
      adjCountEvt = 1'b0; adjFastClk = 1'b0;
      chk("R7 fast clock blocks", gr, MARK);
      chk("R7 fast clock flag", capFlag, 0);
    end

    // R9 set beats clear, then clear
    cfgWrite(4'b1100);
    prep();
    adjCountEvt = 1'b1; flagClr = 1'b1;
    @(posedge clk); @(negedge clk);
    adjCountEvt = 1'b0; flagClr = 1'b0;
    chk("R9 set wins", capFlag, 1);
    repeat (2) @(negedge clk);
    chk("R9 sticky", capFlag, 1);
    flagClr = 1'b1;
    @(posedge clk); @(negedge clk);
    flagClr = 1'b0;
    chk("R9 clear", capFlag, 0);

    // R10 capture beats write; plain write
    regWe = 1'b1; regData = 16'h1234; adjCountEvt = 1'b1; e = cnt;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0; adjCountEvt = 1'b0;
    chk("R10 capture priority", gr, e);
    regWe = 1'b1; regData = 16'h5A5A;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0;
    chk("R10 write", gr, 16'h5A5A);

    // R8 buffer mode blocks capture and compare
    bufferMode = 1'b1;
    cfgWrite(4'b1000);
    capEdge(1'b1, 1'b0, "R8 capture blocked");
    capPin = 1'b0;
    repeat (4) @(negedge clk);
    cfgWrite(4'b1100);
    prep();
    adjCountEvt = 1'b1;
    @(posedge clk); @(negedge clk);
    adjCountEvt = 1'b0;
    chk("R8 event blocked", gr, MARK);
    cfgWrite(4'b0011);
    pulseMatch();
    chk("R8 toggle blocked", outPin, 0);
    cfgWrite(4'b0101);
    pulseMatch();
    chk("R8 clear blocked", outPin, 1);
    bufferMode = 1'b0;
    pulseMatch();
    chk("R3 clear after buffer", outPin, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule